// File: doc/BRIEF.md
# Tree Search Road Refiner

The refiner accepts one coarse ("fat") road at a time. Each road comes with an identifier, a per-layer hit mask and, for every layer, four occupancy bits for the four finer sub-superstrips. The refiner narrows the road in two binary steps. The first step splits the superstrip of every layer into a lower half and an upper half. The second step splits each half again, so that each leaf is one of the four quarters. A node is kept only when enough layers still show hits inside it. Enough means at least the programmed threshold, counting only layers whose coarse mask bit is set. A half that is dropped takes both of its quarters with it.

Each surviving quarter leaves the block as a thin-road record on a valid/ready stream. A record holds the parent identifier and a 2-bit sub-index for every layer. The input side is also valid/ready. A new fat road is taken only when the block is idle, which means every record of the previous road has been handed off. Back-pressure on the output holds the current record in place and keeps `in_ready` low, so an upstream source simply waits. If no half survives, or no quarter survives, the road produces nothing and the block returns to idle early.

Top module: `tsr_road_refiner`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R2: `in_ready` is 1 exactly when the block is idle and `busy` is its complement. A road is taken on a rising edge where `in_valid` and `in_ready` are both 1, and the block is busy in the following cycle.
- R3: Half h (0 = quarters 0 and 1, 1 = quarters 2 and 3) survives when at least `cfg_threshold` layers have their mask bit set and at least one of that half's two sub-bits set. The sub-bit for layer l and quarter q is `in_sub_map[4*l+q]`.
- R4: Quarter q is emitted exactly when its half survives and at least `cfg_threshold` layers have their mask bit and sub-bit q set. With a threshold of 0, all four quarters are emitted.
- R5: Records of one road leave in ascending quarter order, one per output handshake. While `out_valid` is 1 and `out_ready` is 0, the record does not change.
- R6: Every record carries the accepted road identifier on `out_road_id`. Every 2-bit layer field `out_sub_idx[2*l+1:2*l]` holds the quarter index q, whose upper bit is the first-level half and whose lower bit is the second-level half.
- R7: When at least one quarter survives, `out_valid` first rises in the cycle after the second rising edge that follows the accepting edge.
- R8: When no half survives, `in_ready` is 1 again after the first edge following acceptance. When halves survive but no quarter does, `in_ready` is 1 again after the second edge. In both cases no record is produced.
- R9: The threshold, identifier, mask and sub-bits are captured at acceptance. Changes on those pins while busy do not affect the records of the road in progress.
- R10: A layer whose mask bit is clear never counts towards a node, whatever its sub-bits.
- R11: `in_ready` is 1 in the cycle after the handshake of the last record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_threshold | input | TH_W (4) | Minimum number of counted layers for a node to survive |
| in_valid | input | 1 | Fat road offered |
| in_ready | output | 1 | Block idle and able to take a road |
| in_road_id | input | ROAD_W (16) | Identifier of the fat road |
| in_layer_map | input | LAYERS (8) | Per-layer coarse hit mask |
| in_sub_map | input | 4*LAYERS (32) | Four sub-superstrip occupancy bits per layer, quarter q of layer l at bit 4*l+q |
| out_valid | output | 1 | Thin-road record present |
| out_ready | input | 1 | Downstream takes the record |
| out_road_id | output | ROAD_W (16) | Parent road identifier |
| out_sub_idx | output | 2*LAYERS (16) | 2-bit quarter index per layer |
| busy | output | 1 | A road is being refined or emitted |

## Verification
On every cycle, the assertions check the stream rules. These are: a held record stays unchanged under back-pressure, quarter indices rise within a road, all layer fields agree, no output appears in the first cycle of a refinement, and acceptance always leads to a busy cycle. The threshold arithmetic is covered only by the bench scenarios, which compare against a behavioural model on every clock. That includes which halves and quarters survive, that masked layers are ignored, the thresholds 0 and above the layer count, and the early return to idle on a pruned road. The same holds for capture of the threshold at acceptance.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned HALVES  = 2;
  localparam int unsigned LEAVES  = 4;
  localparam int unsigned IDX_W   = $clog2(LEAVES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALF = 2'd1,
    ST_LEAF = 2'd2,
    ST_EMIT = 2'd3
  } tsr_state_e;
endpackage

// File: rtl/tsr_node_eval.sv
module tsr_node_eval #(
  parameter int unsigned LAYERS = 8,
  parameter int unsigned TH_W   = $clog2(LAYERS + 1)
) (
  input  logic [LAYERS-1:0] layer_en,
  input  logic [LAYERS-1:0] occ,
  input  logic [TH_W-1:0]   threshold,
  output logic              pass
);
  logic [TH_W-1:0] count;

  always_comb begin
    count = '0;
    for (int l = 0; l < LAYERS; l++) begin
      if (layer_en[l] && occ[l]) count = count + 1'b1;
    end
    pass = (count >= threshold);
  end
endmodule

// File: rtl/tsr_leaf_pick.sv
module tsr_leaf_pick #(
  parameter int unsigned N   = 4,
  parameter int unsigned IW  = $clog2(N)
) (
  input  logic [N-1:0]  pending,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          last
);
  always_comb begin
    onehot = pending & (~pending + 1'b1);
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) idx = IW'(i);
    end
    last = ((pending & ~onehot) == '0);
  end
endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       any_half,
  input  logic       any_leaf,
  input  logic       out_ready,
  input  logic       last_leaf,
  output tsr_state_e state
);
  tsr_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (accept) nxt = ST_HALF;
      ST_HALF: nxt = any_half ? ST_LEAF : ST_IDLE;
      ST_LEAF: nxt = any_leaf ? ST_EMIT : ST_IDLE;
      ST_EMIT: if (out_ready && last_leaf) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tsr_road_refiner.sv
module tsr_road_refiner
  import tsr_pkg::*;
#(
  parameter int unsigned LAYERS = 8,
  parameter int unsigned ROAD_W = 16,
  parameter int unsigned TH_W   = $clog2(LAYERS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TH_W-1:0]          cfg_threshold,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ROAD_W-1:0]        in_road_id,
  input  logic [LAYERS-1:0]        in_layer_map,
  input  logic [LEAVES*LAYERS-1:0] in_sub_map,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ROAD_W-1:0]        out_road_id,
  output logic [IDX_W*LAYERS-1:0]  out_sub_idx,
  output logic                     busy
);
  tsr_state_e               state;
  logic                     accept;
  logic [ROAD_W-1:0]        road_r;
  logic [LAYERS-1:0]        lmap_r;
  logic [LEAVES*LAYERS-1:0] sub_r;
  logic [TH_W-1:0]          thr_r;
  logic [HALVES-1:0]        half_pass, half_r;
  logic [LEAVES-1:0]        leaf_pass, leaf_keep, pend_r;
  logic [LEAVES-1:0]        pick_onehot;
  logic [IDX_W-1:0]         pick_idx;
  logic                     pick_last;

  assign in_ready = (state == ST_IDLE);
  assign busy     = ~in_ready;
  assign accept   = in_valid & in_ready;

  // first level: a half is occupied on a layer if either of its quarters is
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [LAYERS-1:0] occ;
    for (genvar l = 0; l < LAYERS; l++) begin : g_lay
      assign occ[l] = sub_r[LEAVES*l + 2*h] | sub_r[LEAVES*l + 2*h + 1];
    end
    tsr_node_eval #(.LAYERS(LAYERS), .TH_W(TH_W)) u_eval (
      .layer_en (lmap_r),
      .occ      (occ),
      .threshold(thr_r),
      .pass     (half_pass[h])
    );
  end

  // second level: each quarter, kept only below a surviving half
  for (genvar q = 0; q < LEAVES; q++) begin : g_leaf
    logic [LAYERS-1:0] occ;
    for (genvar l = 0; l < LAYERS; l++) begin : g_lay
      assign occ[l] = sub_r[LEAVES*l + q];
    end
    tsr_node_eval #(.LAYERS(LAYERS), .TH_W(TH_W)) u_eval (
      .layer_en (lmap_r),
      .occ      (occ),
      .threshold(thr_r),
      .pass     (leaf_pass[q])
    );
    assign leaf_keep[q] = leaf_pass[q] & half_r[q / 2];
  end

  tsr_leaf_pick #(.N(LEAVES), .IW(IDX_W)) u_pick (
    .pending(pend_r),
    .onehot (pick_onehot),
    .idx    (pick_idx),
    .last   (pick_last)
  );

  tsr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .any_half (|half_pass),
    .any_leaf (|leaf_keep),
    .out_ready(out_ready),
    .last_leaf(pick_last),
    .state    (state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      road_r <= '0;
      lmap_r <= '0;
      sub_r  <= '0;
      thr_r  <= '0;
      half_r <= '0;
      pend_r <= '0;
    end else begin
      if (accept) begin
        road_r <= in_road_id;
        lmap_r <= in_layer_map;
        sub_r  <= in_sub_map;
        thr_r  <= cfg_threshold;
      end
      if (state == ST_HALF) half_r <= half_pass;
      if (state == ST_LEAF) pend_r <= leaf_keep;
      else if (state == ST_EMIT && out_ready) pend_r <= pend_r & ~pick_onehot;
    end
  end

  assign out_valid   = (state == ST_EMIT);
  assign out_road_id = road_r;
  for (genvar l = 0; l < LAYERS; l++) begin : g_out
    assign out_sub_idx[IDX_W*l +: IDX_W] = pick_idx;
  end
endmodule

// File: rtl/tsr_road_refiner_chk.sv
module tsr_road_refiner_chk #(
  parameter int unsigned LAYERS = 8,
  parameter int unsigned ROAD_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [ROAD_W-1:0]     out_road_id,
  input logic [2*LAYERS-1:0]   out_sub_idx,
  input logic                  busy
);
  // R5: held record under back-pressure
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_road_id) && $stable(out_sub_idx));

  // R5: quarter index strictly rises within one road
  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || (out_sub_idx[1:0] > $past(out_sub_idx[1:0])));

  // R2: acceptance leads to a busy, non-accepting cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !in_ready);

  // R7: no record in the cycle right after acceptance
  a_r7_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !out_valid);

  // R6: identifier fixed for the whole busy period
  a_r6_road_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(out_road_id));

  // R6: every layer field carries the same quarter
  for (genvar l = 1; l < LAYERS; l++) begin : g_uni
    a_r6_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_sub_idx[2*l +: 2] == out_sub_idx[1:0]);
  end
endmodule

bind tsr_road_refiner tsr_road_refiner_chk #(.LAYERS(LAYERS), .ROAD_W(ROAD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_road_id(out_road_id),
  .out_sub_idx(out_sub_idx),
  .busy       (busy)
);

// File: tb/tsr_road_refiner_tb.sv
module tsr_road_refiner_tb;
  localparam int L  = 8;
  localparam int RW = 16;
  localparam int TW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [TW-1:0] cfg_threshold = '0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [RW-1:0] in_road_id = '0;
  logic [L-1:0]  in_layer_map = '0;
  logic [4*L-1:0] in_sub_map = '0;
  logic          out_valid;
  logic          out_ready = 1;
  logic [RW-1:0] out_road_id;
  logic [2*L-1:0] out_sub_idx;
  logic          busy;

  always #2.5 clk = ~clk;

  tsr_road_refiner u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
    .in_valid(in_valid), .in_ready(in_ready), .in_road_id(in_road_id),
    .in_layer_map(in_layer_map), .in_sub_map(in_sub_map),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_road_id(out_road_id), .out_sub_idx(out_sub_idx), .busy(busy)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  int    ready_mode = 0;
  bit    done = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", cur_req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 half step, 2 quarter step, 3 emitting
  int            m_state = 0;
  int            m_q[$];
  logic [RW-1:0] m_road;
  bit            m_half_any;
  bit            m_acc;

  function automatic int count_layers(input logic [L-1:0] m, input logic [4*L-1:0] s,
                                      input int a, input int b);
    int c = 0;
    for (int l = 0; l < L; l++)
      if (m[l] && (s[4*l+a] || s[4*l+b])) c++;
    return c;
  endfunction

  always @(posedge clk) begin
    m_acc = 0;
    if (!rst_n) begin
      m_state = 0;
      m_q.delete();
    end else begin
      case (m_state)
        0: if (in_valid) begin
          m_acc = 1;
          m_road = in_road_id;
          m_q.delete();
          m_half_any = 0;
          for (int h = 0; h < 2; h++)
            if (count_layers(in_layer_map, in_sub_map, 2*h, 2*h+1) >= int'(cfg_threshold))
              m_half_any = 1;
          for (int q = 0; q < 4; q++)
            if (count_layers(in_layer_map, in_sub_map, 2*(q/2), 2*(q/2)+1) >= int'(cfg_threshold) &&
                count_layers(in_layer_map, in_sub_map, q, q) >= int'(cfg_threshold))
              m_q.push_back(q);
          m_state = 1;
        end
        1: m_state = m_half_any ? 2 : 0;
        2: m_state = (m_q.size() > 0) ? 3 : 0;
        3: if (out_ready) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_state = 0;
        end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (ready_mode == 1)      out_ready = ~out_ready;
    else if (ready_mode == 2) out_ready = 1'($urandom % 2);
    else                      out_ready = 1;
  end

  // every-cycle comparison (R2, R7, R8, R11 on handshake pins; R6 on records)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_ready == (m_state == 0), "R2 in_ready", in_ready, m_state == 0);
      chk(busy == (m_state != 0), "R2 busy", busy, m_state != 0);
      chk(out_valid == (m_state == 3), "R7 out_valid", out_valid, m_state == 3);
      if (out_valid && m_state == 3) begin
        logic [2*L-1:0] e;
        for (int l = 0; l < L; l++) e[2*l +: 2] = 2'(m_q[0]);
        chk(out_road_id == m_road, "R6 out_road_id", out_road_id, m_road);
        chk(out_sub_idx == e, "R6 out_sub_idx", out_sub_idx, e);
      end
    end
  end

  task automatic send(input logic [RW-1:0] id, input logic [L-1:0] m,
                      input logic [4*L-1:0] s, input logic [TW-1:0] t, input bit disturb);
    @(negedge clk);
    in_valid = 1; in_road_id = id; in_layer_map = m; in_sub_map = s; cfg_threshold = t;
    do begin @(posedge clk); #1; end while (!m_acc);
    @(negedge clk);
    in_valid = 0;
    if (disturb) begin
      cfg_threshold = ~t; in_road_id = ~id; in_layer_map = ~m; in_sub_map = ~s;
    end
    while (m_state != 0) @(negedge clk);
  endtask

  function automatic logic [4*L-1:0] rep(input logic [3:0] nib);
    logic [4*L-1:0] r;
    for (int l = 0; l < L; l++) r[4*l +: 4] = nib;
    return r;
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act %0d exp %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);

    cur_req = "R3";   // single quarter 0 on all layers
    send(16'h1111, 8'hFF, rep(4'b0001), 4'd6, 0);
    cur_req = "R5";   // all quarters, toggling back-pressure
    ready_mode = 1;
    send(16'h2222, 8'hFF, rep(4'b1111), 4'd8, 0);
    ready_mode = 0;
    cur_req = "R10";  // masked layers ignored: only 4 count, threshold 5
    send(16'h3333, 8'h0F, rep(4'b1111), 4'd5, 0);
    cur_req = "R4";   // threshold 0 gives all four quarters
    send(16'h4444, 8'h00, '0, 4'd0, 0);
    cur_req = "R8";   // threshold above layer count: no half
    send(16'h5555, 8'hFF, rep(4'b1111), 4'd9, 0);
    cur_req = "R8";   // halves survive (8 layers each) but no quarter reaches 5
    begin
      logic [4*L-1:0] s = '0;
      for (int l = 0; l < L; l++) s[4*l + (l % 2)] = 1'b1;
      for (int l = 0; l < L; l++) s[4*l + 2 + (l % 2)] = 1'b1;
      send(16'h5A5A, 8'hFF, s, 4'd5, 0);
    end
    cur_req = "R4";   // mixed: quarter 1 on layers 0-5, quarter 2 on layers 2-7
    begin
      logic [4*L-1:0] s = '0;
      for (int l = 0; l < 6; l++) s[4*l + 1] = 1'b1;
      for (int l = 2; l < 8; l++) s[4*l + 2] = 1'b1;
      send(16'h6666, 8'hFF, s, 4'd6, 0);
    end
    cur_req = "R9";   // pins disturbed while busy
    ready_mode = 1;
    send(16'h7777, 8'hFF, rep(4'b0110), 4'd7, 1);
    ready_mode = 2;
    cur_req = "R11";
    for (int i = 0; i < 60; i++)
      send(16'($urandom), 8'($urandom), 32'($urandom), 4'($urandom % 10), i[0]);
    ready_mode = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule